// File: doc/BRIEF.md
# Pseudo-Random Memory Region Tester

This block exercises one region of memory through a simple host request port. After reset it sits in an initialization phase. When the run input is high it fills every word of its region with a reproducible pseudo-random sequence. It then restarts the generator from the same seed, reads each word back and compares it with the regenerated value. The outcome is shown on a three-lamp status output.

The region's start address and length are parameters. Two instances can therefore test the lower and the upper half of one memory, each through its own port of a port splitter. While run stays high the test repeats. When run is low the final pass or fail indication is held.

The memory port uses a level request with an acknowledge. A write request is held until the memory signals that the write has begun. A read request is held until the read data is returned with its acknowledge.

Top module: `region_tester`

## Requirements
- R1: After reset the tester is in initialization. Status reads 3'b001 and neither `mem_wr` nor `mem_rd` is asserted. It stays there while `run` is low. The status vector is {lamp2, lamp1, lamp0}, and initialization lights lamp0 only.
- R2: A clock edge with `run` high in initialization starts the write phase, with status 3'b010. It writes LEN words to addresses BASE, BASE+1, … BASE+LEN-1 in rising order. Word 0 is SEED. Each next word is the previous word shifted right by one, XORed with TAPS when the shifted-out bit was 1. The defaults SEED=16'hACE1 and TAPS=16'hB400 give a maximal-length sequence that is never zero.
- R3: A request stays asserted with its address and write data unchanged until its acknowledge. The address advances only on `mem_wr_ack` (write begun) or `mem_rd_ack` (read data valid). `mem_wr` and `mem_rd` are never high together.
- R4: The acknowledge of the last write starts the read phase, with status 3'b100. It reads the same LEN addresses in the same order and compares each `mem_rdata` with the sequence regenerated from SEED.
- R5: If every word read back matches, the tester enters the pass state after the last read acknowledge. Status is 3'b000.
- R6: If any word read back differs, including the first or the last word, the tester enters the fail state. Status is 3'b111.
- R7: The pass or fail status is held while `run` is low. A clock edge with `run` high returns the tester to initialization for one cycle. If `run` stays high, the test then restarts, so holding `run` repeats the test continuously.
- R8: The mismatch record is cleared in initialization, so a clean test that follows a failed one reports pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start, and repeat while high |
| mem_wr | output | 1 | Write request, held until acknowledged |
| mem_rd | output | 1 | Read request, held until acknowledged |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W | Write data |
| mem_wr_ack | input | 1 | Write has begun; advance |
| mem_rd_ack | input | 1 | Read data valid on mem_rdata; advance |
| mem_rdata | input | DATA_W | Read data |
| status | output | 3 | Lamps {lamp2, lamp1, lamp0} |

## Verification
Every status change is registered, so it shows one clock edge after its cause. The causes are the run edge, the last write acknowledge, the last read acknowledge, and the run edge in pass or fail. The bench drives inputs and samples outputs on falling edges, so it reads each new status half a cycle after the edge that caused it. It times the run pulse to that single edge, which lets it observe the one-cycle initialization state. The request after an acknowledge is due on the next edge, and the memory model in the bench checks the address and data of each request at the falling edge where it acknowledges that request. With latency inserted, the model also checks that the request stays stable on every waiting cycle.

// File: rtl/rt_pkg.sv
package rt_pkg;
  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_WRITE = 3'd1,
    ST_READ  = 3'd2,
    ST_PASS  = 3'd3,
    ST_FAIL  = 3'd4
  } rt_state_e;

  localparam logic [2:0] LAMP_INIT  = 3'b001;
  localparam logic [2:0] LAMP_WRITE = 3'b010;
  localparam logic [2:0] LAMP_READ  = 3'b100;
  localparam logic [2:0] LAMP_PASS  = 3'b000;
  localparam logic [2:0] LAMP_FAIL  = 3'b111;

  function automatic logic [2:0] lamps_of(rt_state_e s);
    case (s)
      ST_INIT:  return LAMP_INIT;
      ST_WRITE: return LAMP_WRITE;
      ST_READ:  return LAMP_READ;
      ST_PASS:  return LAMP_PASS;
      default:  return LAMP_FAIL;
    endcase
  endfunction
endpackage

// File: rtl/rt_lfsr.sv
module rt_lfsr #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;
  logic         q_en;

  always_comb begin
    q_en   = load | step;
    q_next = q;
    if (load)      q_next = SEED;
    else if (step) q_next = (q >> 1) ^ (q[0] ? TAPS : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= SEED;
    else if (q_en) q <= q_next;
  end

  // R2: the generator must never fall into the all-zero lock-up state
  assert_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n) q != '0);
endmodule

// File: rtl/rt_compare.sv
module rt_compare #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         sample,
  input  logic [W-1:0] got,
  input  logic [W-1:0] expect_w,
  output logic         miss_now,
  output logic         err
);
  logic err_next;

  always_comb begin
    miss_now = sample && (got != expect_w);
    err_next = err;
    if (clear)         err_next = 1'b0;
    else if (miss_now) err_next = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= err_next;
  end

  // R6: once seen, a mismatch is kept until initialization clears it
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clear) |=> err);
  // R8: the clear empties the record
  assert_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !err);
endmodule

// File: rtl/rt_sequencer.sv
module rt_sequencer
  import rt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BASE   = 0,
  parameter int unsigned LEN    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_ack,
  input  logic              rd_ack,
  input  logic              miss_now,
  input  logic              err,
  output rt_state_e         state,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              seed_load,
  output logic              gen_step,
  output logic              cmp_clear,
  output logic              cmp_sample
);
  localparam int unsigned CNT_W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LEN - 1);

  rt_state_e        state_next;
  logic [CNT_W-1:0] offset, offset_next;
  logic             offset_en, adv, last;

  always_comb begin
    mem_wr     = (state == ST_WRITE);
    mem_rd     = (state == ST_READ);
    mem_addr   = ADDR_W'(BASE) + ADDR_W'(offset);
    last       = (offset == LAST);
    adv        = (mem_wr && wr_ack) || (mem_rd && rd_ack);
    seed_load  = (state == ST_INIT) || (mem_wr && wr_ack && last);
    gen_step   = adv;
    cmp_clear  = (state == ST_INIT);
    cmp_sample = mem_rd && rd_ack;
  end

  always_comb begin
    state_next  = state;
    offset_en   = 1'b0;
    offset_next = offset;
    case (state)
      ST_INIT: begin
        offset_en   = 1'b1;
        offset_next = '0;
        if (run) state_next = ST_WRITE;
      end
      ST_WRITE, ST_READ: begin
        if (adv) begin
          offset_en   = 1'b1;
          offset_next = last ? '0 : offset + 1'b1;
          if (last) begin
            if (state == ST_WRITE)      state_next = ST_READ;
            else if (err || miss_now)   state_next = ST_FAIL;
            else                        state_next = ST_PASS;
          end
        end
      end
      default: if (run) state_next = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_INIT;
      offset <= '0;
    end else begin
      state <= state_next;
      if (offset_en) offset <= offset_next;
    end
  end

  // R1: no memory traffic while initializing
  assert_init_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INIT) |-> !(mem_wr || mem_rd));
  // R7: result held while run is low
  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_PASS || state == ST_FAIL) && !run) |=> $stable(state));
  // R7: run in a result state returns to initialization
  assert_run_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_PASS || state == ST_FAIL) && run) |=> (state == ST_INIT));
  // R4: the read phase starts at address BASE
  assert_read_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd) |-> (mem_addr == ADDR_W'(BASE)));
endmodule

// File: rtl/region_tester.sv
module region_tester
  import rt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BASE   = 0,
  parameter int unsigned LEN    = 32,
  parameter logic [DATA_W-1:0] SEED = 16'hACE1,
  parameter logic [DATA_W-1:0] TAPS = 16'hB400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_wr_ack,
  input  logic              mem_rd_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [2:0]        status
);
  rt_state_e         state;
  logic              seed_load, gen_step, cmp_clear, cmp_sample;
  logic              miss_now, err;
  logic [DATA_W-1:0] pattern;

  rt_sequencer #(.ADDR_W(ADDR_W), .BASE(BASE), .LEN(LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run),
    .wr_ack(mem_wr_ack), .rd_ack(mem_rd_ack),
    .miss_now(miss_now), .err(err),
    .state(state), .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .seed_load(seed_load), .gen_step(gen_step),
    .cmp_clear(cmp_clear), .cmp_sample(cmp_sample)
  );

  rt_lfsr #(.W(DATA_W), .SEED(SEED), .TAPS(TAPS)) u_gen (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .step(gen_step), .q(pattern)
  );

  rt_compare #(.W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clear(cmp_clear), .sample(cmp_sample),
    .got(mem_rdata), .expect_w(pattern), .miss_now(miss_now), .err(err)
  );

  always_comb begin
    mem_wdata = pattern;
    status    = lamps_of(state);
  end

  // R3: one request kind at a time
  assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd));
  // R3: an unacknowledged write keeps address and data
  assert_hold_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_wr_ack) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));
  // R3: an unacknowledged read keeps its address
  assert_hold_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_rd_ack) |=> (mem_rd && $stable(mem_addr)));
  // R2: each write phase starts with the seed at the region base
  assert_write_seed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr) |-> (mem_wdata == SEED && mem_addr == ADDR_W'(BASE)));
endmodule

// File: tb/tb_region_tester.sv
module tb_region_tester;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int BASE = 256;
  localparam int LEN = 24;
  localparam logic [DW-1:0] SEED = 16'hACE1;
  localparam logic [DW-1:0] TAPS = 16'hB400;

  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } item_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, run;
  logic mem_wr, mem_rd, mem_wr_ack, mem_rd_ack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [2:0] status;

  region_tester #(.ADDR_W(AW), .DATA_W(DW), .BASE(BASE), .LEN(LEN),
                  .SEED(SEED), .TAPS(TAPS)) dut (
    .clk(clk), .rst_n(rst_n), .run(run),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wr_ack(mem_wr_ack), .mem_rd_ack(mem_rd_ack), .mem_rdata(mem_rdata),
    .status(status)
  );

  logic [DW-1:0] mem [0:(1<<AW)-1];
  item_t wq[$], rq[$];
  int checks = 0, fails = 0;
  int lat = 0, bad_idx = -1, wait_cnt = 0;
  logic [AW-1:0] held_a;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] nxt(input logic [DW-1:0] v);
    return (v >> 1) ^ (v[0] ? TAPS : '0);
  endfunction

  // driver side of the scoreboard: expected writes and reads for one test
  task automatic push_expected();
    logic [DW-1:0] v = SEED;
    for (int i = 0; i < LEN; i++) begin
      wq.push_back({AW'(BASE + i), v});
      rq.push_back({AW'(BASE + i), v});
      v = nxt(v);
    end
  endtask

  // memory model and monitor: acknowledge after lat waiting cycles
  always @(negedge clk) begin
    mem_wr_ack <= 1'b0;
    mem_rd_ack <= 1'b0;
    if (rst_n && (mem_wr || mem_rd)) begin
      check(!(mem_wr && mem_rd), "R3", {30'd0, mem_wr, mem_rd}, 32'h0);
      if (wait_cnt > 0)
        check(mem_addr == held_a, "R3", 32'(mem_addr), 32'(held_a));
      else
        held_a = mem_addr;
      if (wait_cnt >= lat) begin
        wait_cnt = 0;
        if (mem_wr) begin
          item_t e;
          mem[mem_addr] = mem_wdata;
          mem_wr_ack <= 1'b1;
          if (wq.size() == 0) check(1'b0, "R2", 32'(mem_addr), 32'hFFFF_FFFF);
          else begin
            e = wq.pop_front();
            check({mem_addr, mem_wdata} == e, "R2", 32'({mem_addr, mem_wdata}), 32'(e));
          end
        end else begin
          item_t e;
          mem_rdata <= mem[mem_addr] ^ ((32'(mem_addr) == BASE + bad_idx) ? 16'h0100 : 16'h0);
          mem_rd_ack <= 1'b1;
          if (rq.size() == 0) check(1'b0, "R4", 32'(mem_addr), 32'hFFFF_FFFF);
          else begin
            e = rq.pop_front();
            check(mem_addr == e.a, "R4", 32'(mem_addr), 32'(e.a));
          end
        end
      end else wait_cnt++;
    end
  end

  task automatic wait_status(input logic [2:0] s, input string req);
    int n = 0;
    while (status != s && n < 2000) begin @(negedge clk); n++; end
    check(status == s, req, 32'(status), 32'(s));
  endtask

  // from initialization: one edge with run high starts writing
  task automatic start_from_init();
    push_expected();
    run = 1'b1;
    @(negedge clk);
    check(status == 3'b010, "R2", 32'(status), 32'h2);
    run = 1'b0;
  endtask

  // from pass or fail: run edge gives one cycle of initialization
  task automatic start_from_done();
    push_expected();
    run = 1'b1;
    @(negedge clk);
    check(status == 3'b001, "R7", 32'(status), 32'h1);
    @(negedge clk);
    check(status == 3'b010, "R2", 32'(status), 32'h2);
    run = 1'b0;
  endtask

  task automatic finish_test(input logic [2:0] res, input string req);
    wait_status(3'b100, "R4");
    if (res == 3'b000) wait_status(3'b000, req);
    else               wait_status(3'b111, req);
    check(wq.size() == 0 && rq.size() == 0, "R4", 32'(wq.size() + rq.size()), 32'h0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run = 1'b0;
    repeat (3) @(negedge clk);
    check(status == 3'b001, "R1", 32'(status), 32'h1);
    check(!mem_wr && !mem_rd, "R1", {30'd0, mem_wr, mem_rd}, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(status == 3'b001 && !mem_wr && !mem_rd, "R1", 32'(status), 32'h1);

    // clean test, no latency
    lat = 0; bad_idx = -1;
    start_from_init();
    finish_test(3'b000, "R5");
    repeat (10) @(negedge clk);
    check(status == 3'b000, "R7", 32'(status), 32'h0);

    // first word corrupted, latency 2
    lat = 2; bad_idx = 0;
    start_from_done();
    finish_test(3'b111, "R6");
    repeat (10) @(negedge clk);
    check(status == 3'b111, "R7", 32'(status), 32'h7);

    // last word corrupted, latency 1
    lat = 1; bad_idx = LEN - 1;
    start_from_done();
    finish_test(3'b111, "R6");

    // clean test after a failure passes
    lat = 0; bad_idx = -1;
    start_from_done();
    finish_test(3'b000, "R8");

    // run held high: test repeats by itself
    lat = 1;
    push_expected(); push_expected();
    run = 1'b1;
    @(negedge clk);
    check(status == 3'b001, "R7", 32'(status), 32'h1);
    wait_status(3'b000, "R7");
    @(negedge clk);
    check(status == 3'b001, "R7", 32'(status), 32'h1);
    @(negedge clk);
    check(status == 3'b010, "R7", 32'(status), 32'h2);
    run = 1'b0;
    finish_test(3'b000, "R5");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule